// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block brings a DDR2 SDRAM from power-on to the point where its extended mode registers are loaded. After a start pulse it waits out the supply settling time, then releases the pad DLL from reset and waits for it to lock. It then raises the clock enable, waits briefly, precharges all banks and writes the three extended mode registers in a fixed order. The pad drive-strength, termination and calibration settings are copied into the last mode-register write, so the memory and the pad always agree. All waits come from one down-counter whose lengths are derived from the clock frequency parameter.

When the system is resuming from a supply-backup state, the start pulse is taken with the recovery flag set. The block then skips every step and reports completion at once, leaving the memory untouched. Refresh, the final mode-register load, data traffic and register access from a processor are handled elsewhere.

Top module: `ddr2_init_seq`

## Requirements
- R1: While rst_ni is low: cke_o=0, dll_rst_o=0, done_o=0, freq_o=0, ba_o=0, addr_o=0, and the command pins {cs_n,ras_n,cas_n,we_n} show NOP = 0,1,1,1.
- R2: A start_i pulse sampled in idle with backup_i=0 begins a settling wait of STAB_CYC = CLK_MHZ*STAB_US cycles (5000 at defaults), during which every output keeps its reset value.
- R3: A start_i pulse sampled in idle with backup_i=1 sets done_o in the next cycle, issues no command, and leaves cke_o and dll_rst_o low.
- R4: After the settling wait, one cycle with dll_rst_o low captures freq_i onto freq_o; dll_rst_o then goes high and stays high for a DLL wait of STAB_CYC cycles, so both waits together cover at least 200 us.
- R5: cke_o rises right after the DLL wait and stays high until reset; it is held for CKE_CYC = ceil(CKE_NS*CLK_MHZ/1000) cycles (20 at defaults) before the first command, and no command is issued while cke_o is low.
- R6: The first command is precharge-all: pins 0,0,1,0, addr_o bit 10 set, all other address bits and ba_o zero.
- R7: Three mode-register commands (pins 0,0,0,0) follow in the order ba_o=2, ba_o=3, ba_o=1; the first two carry addr_o=0.
- R8: In the ba_o=1 command, addr_o bit 1 equals dic_i, bit 2 equals odt_i[0], bit 6 equals odt_i[1], bits 9:7 equal ocd_i, and all other address bits are zero.
- R9: Successive commands start exactly CMD_GAP cycles apart (2 at defaults) and NOP is driven in every cycle without a command.
- R10: done_o rises CMD_GAP cycles after the last mode-register command and stays high until reset.
- R11: A start_i pulse while the sequence is running or finished changes neither the timing nor the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin |
| backup_i | input | 1 | Resume from supply backup: skip the sequence |
| freq_i | input | FREQ_W | Pad frequency code |
| dic_i | input | 1 | Output drive strength select |
| odt_i | input | 2 | On-die termination select |
| ocd_i | input | 3 | Off-chip driver calibration mode |
| cke_o | output | 1 | Memory clock enable |
| dll_rst_o | output | 1 | Pad DLL reset release (high = running) |
| freq_o | output | FREQ_W | Frequency code captured for the pad |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | BA_W | Bank address |
| addr_o | output | ROW_W | Address bus |
| done_o | output | 1 | Early sequence complete (level) |

## Verification
The hardest case to reach is a second start pulse arriving deep inside a long wait, since it could restart or shorten the counter without changing any output until thousands of cycles later. The bench fires such a pulse during the settling wait and another after completion, and a scoreboard then demands every command at its exact absolute cycle, so any restart shows up as a timing mismatch. Two normal runs with different pad fields and frequency codes expose the EMRS(1) bit mapping, and a recovery run with the flag set checks that nothing is issued.

// File: rtl/ddr2_init_pkg.sv
`timescale 1ns/1ps
package ddr2_init_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PWR_WAIT,
    ST_DLL_LATCH,
    ST_DLL_WAIT,
    ST_CKE_WAIT,
    ST_PALL,
    ST_MRS,
    ST_GAP,
    ST_DONE,
    ST_BYPASS
  } seq_state_e;

  typedef enum logic [1:0] {
    CMD_NOP,
    CMD_PALL,
    CMD_MRS
  } cmd_kind_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_pins_t;

  localparam cmd_pins_t PINS_NOP  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam cmd_pins_t PINS_PALL = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
  localparam cmd_pins_t PINS_MRS  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

  // bit positions decoded by the memory
  localparam int unsigned ADDR_AP_BIT   = 10;
  localparam int unsigned EM1_DIC_BIT   = 1;
  localparam int unsigned EM1_RTT0_BIT  = 2;
  localparam int unsigned EM1_RTT1_BIT  = 6;
  localparam int unsigned EM1_OCD_LSB   = 7;
  localparam int unsigned OCD_W         = 3;
  localparam int unsigned ODT_W         = 2;

endpackage

// File: rtl/ddr2_init_timer.sv
`timescale 1ns/1ps
module ddr2_init_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             expired_o
);

  logic [CNT_W-1:0] cnt_q;

  // a wait of len_i cycles: len_i-1 down to 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (load_i)             cnt_q <= len_i - CNT_W'(1);
    else if (cnt_q != '0)        cnt_q <= cnt_q - CNT_W'(1);
  end

  assign expired_o = (cnt_q == '0);

  AST_LOAD_LEN_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (len_i != '0)); // R2

endmodule

// File: rtl/ddr2_init_cmd_enc.sv
`timescale 1ns/1ps
module ddr2_init_cmd_enc
  import ddr2_init_pkg::*;
#(
  parameter int unsigned ROW_W = 14,
  parameter int unsigned BA_W  = 3
) (
  input  cmd_kind_e        cmd_i,
  input  logic [BA_W-1:0]  bank_i,
  input  logic             dic_i,
  input  logic [ODT_W-1:0] odt_i,
  input  logic [OCD_W-1:0] ocd_i,
  output cmd_pins_t        pins_o,
  output logic [BA_W-1:0]  ba_o,
  output logic [ROW_W-1:0] addr_o
);

  logic [ROW_W-1:0] em1_addr;

  always_comb begin
    em1_addr = '0;
    em1_addr[EM1_DIC_BIT]  = dic_i;
    em1_addr[EM1_RTT0_BIT] = odt_i[0];
    em1_addr[EM1_RTT1_BIT] = odt_i[1];
    for (int i = 0; i < int'(OCD_W); i++) begin
      em1_addr[EM1_OCD_LSB + i] = ocd_i[i];
    end
  end

  always_comb begin
    pins_o = PINS_NOP;
    ba_o   = '0;
    addr_o = '0;
    unique case (cmd_i)
      CMD_PALL: begin
        pins_o              = PINS_PALL;
        addr_o[ADDR_AP_BIT] = 1'b1;
      end
      CMD_MRS: begin
        pins_o = PINS_MRS;
        ba_o   = bank_i;
        if (bank_i == BA_W'(1)) addr_o = em1_addr;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/ddr2_init_seq.sv
`timescale 1ns/1ps
module ddr2_init_seq
  import ddr2_init_pkg::*;
#(
  parameter int unsigned CLK_MHZ = 50,
  parameter int unsigned STAB_US = 100,
  parameter int unsigned CKE_NS  = 400,
  parameter int unsigned CMD_GAP = 2,
  parameter int unsigned FREQ_W  = 4,
  parameter int unsigned ROW_W   = 14,
  parameter int unsigned BA_W    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              backup_i,
  input  logic [FREQ_W-1:0] freq_i,
  input  logic              dic_i,
  input  logic [1:0]        odt_i,
  input  logic [2:0]        ocd_i,
  output logic              cke_o,
  output logic              dll_rst_o,
  output logic [FREQ_W-1:0] freq_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ROW_W-1:0]  addr_o,
  output logic              done_o
);

  localparam int unsigned STAB_CYC = CLK_MHZ * STAB_US;
  localparam int unsigned CKE_RAW  = (CKE_NS * CLK_MHZ + 999) / 1000;
  localparam int unsigned CKE_CYC  = (CKE_RAW == 0) ? 1 : CKE_RAW;
  localparam int unsigned GAP_CYC  = (CMD_GAP < 2) ? 1 : CMD_GAP - 1;
  localparam int unsigned MAX_CYC  = (STAB_CYC > CKE_CYC) ? STAB_CYC : CKE_CYC;
  localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);
  localparam int unsigned N_CMDS   = 4; // precharge-all plus three mode writes

  seq_state_e        state_q, state_d;
  logic [2:0]        step_q, step_d;
  logic [FREQ_W-1:0] freq_q;
  logic              tmr_load;
  logic [CNT_W-1:0]  tmr_len;
  logic              tmr_expired;
  cmd_kind_e         cmd_kind;
  logic [BA_W-1:0]   mr_bank;
  cmd_pins_t         pins;
  logic              cmd_valid;

  ddr2_init_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .len_i     (tmr_len),
    .expired_o (tmr_expired)
  );

  always_comb begin
    state_d  = state_q;
    step_d   = step_q;
    tmr_load = 1'b0;
    tmr_len  = CNT_W'(STAB_CYC);
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        if (backup_i) state_d = ST_BYPASS;
        else begin
          state_d  = ST_PWR_WAIT;
          tmr_load = 1'b1;
        end
      end
      ST_PWR_WAIT: if (tmr_expired) state_d = ST_DLL_LATCH;
      ST_DLL_LATCH: begin
        state_d  = ST_DLL_WAIT;
        tmr_load = 1'b1;
      end
      ST_DLL_WAIT: if (tmr_expired) begin
        state_d  = ST_CKE_WAIT;
        tmr_load = 1'b1;
        tmr_len  = CNT_W'(CKE_CYC);
      end
      ST_CKE_WAIT: if (tmr_expired) state_d = ST_PALL;
      ST_PALL, ST_MRS: begin
        state_d  = ST_GAP;
        step_d   = step_q + 3'd1;
        tmr_load = 1'b1;
        tmr_len  = CNT_W'(GAP_CYC);
      end
      ST_GAP: if (tmr_expired) begin
        state_d = (step_q == 3'(N_CMDS)) ? ST_DONE : ST_MRS;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      freq_q  <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      if (state_q == ST_DLL_LATCH) freq_q <= freq_i;
    end
  end

  // mode-register order: 2, 3, then 1
  always_comb begin
    unique case (step_q)
      3'd1:    mr_bank = BA_W'(2);
      3'd2:    mr_bank = BA_W'(3);
      default: mr_bank = BA_W'(1);
    endcase
  end

  always_comb begin
    unique case (state_q)
      ST_PALL: cmd_kind = CMD_PALL;
      ST_MRS:  cmd_kind = CMD_MRS;
      default: cmd_kind = CMD_NOP;
    endcase
  end

  ddr2_init_cmd_enc #(.ROW_W(ROW_W), .BA_W(BA_W)) u_enc (
    .cmd_i  (cmd_kind),
    .bank_i (mr_bank),
    .dic_i  (dic_i),
    .odt_i  (odt_i),
    .ocd_i  (ocd_i),
    .pins_o (pins),
    .ba_o   (ba_o),
    .addr_o (addr_o)
  );

  assign cs_n_o    = pins.cs_n;
  assign ras_n_o   = pins.ras_n;
  assign cas_n_o   = pins.cas_n;
  assign we_n_o    = pins.we_n;
  assign cmd_valid = (pins != PINS_NOP);
  assign freq_o    = freq_q;

  assign cke_o = (state_q == ST_CKE_WAIT) || (state_q == ST_PALL) ||
                 (state_q == ST_MRS) || (state_q == ST_GAP) || (state_q == ST_DONE);
  assign dll_rst_o = cke_o || (state_q == ST_DLL_WAIT);
  assign done_o    = (state_q == ST_DONE) || (state_q == ST_BYPASS);

  AST_DLL_BEFORE_CKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_o |-> dll_rst_o); // R4
  AST_CKE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_o |=> cke_o); // R5
  AST_CMD_NEEDS_CKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid |-> cke_o); // R5
  AST_MRS_BANK_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_kind == CMD_MRS) |-> (ba_o != '0)); // R7
  AST_CMD_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid |=> !cmd_valid); // R9
  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o); // R10
  AST_BYPASS_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !cke_o) |-> (!cmd_valid && !dll_rst_o)); // R3

endmodule

// File: tb/tb_ddr2_init_seq.sv
`timescale 1ns/1ps
module tb_ddr2_init_seq;

  localparam int T_STAB = 50 * 100;  // 100 us at 50 MHz
  localparam int T_CKE  = 20;        // 400 ns at 50 MHz
  localparam int GAP    = 2;
  localparam int P_OFF  = 2 * T_STAB + T_CKE + 1; // precharge-all offset

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        backup_i = 1'b0;
  logic [3:0]  freq_i = '0;
  logic        dic_i = 1'b0;
  logic [1:0]  odt_i = '0;
  logic [2:0]  ocd_i = '0;
  logic        cke_o, dll_rst_o, cs_n_o, ras_n_o, cas_n_o, we_n_o, done_o;
  logic [3:0]  freq_o;
  logic [2:0]  ba_o;
  logic [13:0] addr_o;

  ddr2_init_seq dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .backup_i(backup_i),
    .freq_i(freq_i), .dic_i(dic_i), .odt_i(odt_i), .ocd_i(ocd_i),
    .cke_o(cke_o), .dll_rst_o(dll_rst_o), .freq_o(freq_o),
    .cs_n_o(cs_n_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o),
    .ba_o(ba_o), .addr_o(addr_o), .done_o(done_o)
  );

  always #10 clk = ~clk;

  typedef struct {
    logic [3:0]  pins;
    logic [2:0]  ba;
    logic [13:0] addr;
    int          cyc;
    string       tag;
  } exp_t;

  exp_t q[$];
  exp_t e;
  int   cyc = 0;
  int   base = 0;
  int   n_cmp = 0;
  int   n_err = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [13:0] em1_addr(input logic d, input logic [1:0] o, input logic [2:0] c);
    logic [13:0] a = '0;
    a[1] = d; a[2] = o[0]; a[6] = o[1]; a[9:7] = c;
    return a;
  endfunction

  // monitor: every non-NOP command must match the queue head
  always @(negedge clk) begin
    if (rst_ni) begin
      if ({cs_n_o, ras_n_o, cas_n_o, we_n_o} != 4'b0111) begin
        if (q.size() == 0) begin
          chk(1'b0, "R9 unexpected command", {cs_n_o, ras_n_o, cas_n_o, we_n_o}, 4'b0111);
        end else begin
          e = q.pop_front();
          chk({cs_n_o, ras_n_o, cas_n_o, we_n_o} == e.pins, e.tag, {cs_n_o, ras_n_o, cas_n_o, we_n_o}, e.pins);
          chk(ba_o == e.ba, e.tag, ba_o, e.ba);
          chk(addr_o == e.addr, e.tag, addr_o, e.addr);
          chk(cyc == e.cyc, "R9 command cycle", cyc, e.cyc);
        end
      end else begin
        chk(cs_n_o == 1'b0, "R9 NOP chip select", cs_n_o, 0);
      end
    end
  end

  task automatic wait_off(input int k);
    while (cyc < base + k) @(negedge clk);
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni  = 1'b0;
    start_i = 1'b0;
    repeat (2) @(negedge clk);
    chk(cke_o == 1'b0, "R1 cke", cke_o, 0);
    chk(dll_rst_o == 1'b0, "R1 dll", dll_rst_o, 0);
    chk(done_o == 1'b0, "R1 done", done_o, 0);
    chk(freq_o == 4'h0, "R1 freq", freq_o, 0);
    chk({cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'b0111, "R1 nop", {cs_n_o, ras_n_o, cas_n_o, we_n_o}, 4'b0111);
    chk(ba_o == 3'd0 && addr_o == 14'd0, "R1 bus", {ba_o, addr_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic push(input logic [3:0] p, input logic [2:0] b, input logic [13:0] a, input int off, input string tag);
    exp_t x;
    x.pins = p; x.ba = b; x.addr = a; x.cyc = base + off; x.tag = tag;
    q.push_back(x);
  endtask

  task automatic run_normal(input logic [3:0] f, input logic d, input logic [1:0] o, input logic [2:0] c);
    do_reset();
    backup_i = 1'b0; freq_i = f; dic_i = d; odt_i = o; ocd_i = c;
    base = cyc + 1;
    push(4'b0010, 3'd0, 14'h0400, P_OFF, "R6 precharge-all");
    push(4'b0000, 3'd2, 14'h0000, P_OFF + GAP, "R7 EMRS2");
    push(4'b0000, 3'd3, 14'h0000, P_OFF + 2 * GAP, "R7 EMRS3");
    push(4'b0000, 3'd1, em1_addr(d, o, c), P_OFF + 3 * GAP, "R8 EMRS1 fields");
    pulse_start();
    wait_off(100);
    pulse_start(); // R11: ignored while running
    wait_off(T_STAB - 1);
    chk(dll_rst_o == 1'b0 && cke_o == 1'b0, "R2 settling outputs", {dll_rst_o, cke_o}, 0);
    chk(freq_o == 4'h0, "R4 freq before capture", freq_o, 0);
    wait_off(T_STAB);
    chk(dll_rst_o == 1'b0, "R4 dll low in capture cycle", dll_rst_o, 0);
    wait_off(T_STAB + 1);
    chk(dll_rst_o == 1'b1, "R4 dll released", dll_rst_o, 1);
    chk(freq_o == f, "R4 freq captured", freq_o, f);
    wait_off(2 * T_STAB);
    chk(cke_o == 1'b0, "R5 cke before DLL wait end", cke_o, 0);
    wait_off(2 * T_STAB + 1);
    chk(cke_o == 1'b1, "R5 cke rises", cke_o, 1);
    wait_off(P_OFF + 4 * GAP - 1);
    chk(done_o == 1'b0, "R10 done early", done_o, 0);
    wait_off(P_OFF + 4 * GAP);
    chk(done_o == 1'b1, "R10 done", done_o, 1);
    chk(q.size() == 0, "R7 all commands seen", q.size(), 0);
    pulse_start(); // R11: ignored when finished
    repeat (10) @(negedge clk);
    chk(done_o == 1'b1 && cke_o == 1'b1, "R11 state kept after late start", {done_o, cke_o}, 3);
    chk(q.size() == 0, "R11 no extra command", q.size(), 0);
  endtask

  task automatic run_backup();
    do_reset();
    backup_i = 1'b1; freq_i = 4'h9;
    base = cyc + 1;
    pulse_start();
    chk(done_o == 1'b1, "R3 done at once", done_o, 1);
    repeat (50) @(negedge clk);
    chk(cke_o == 1'b0 && dll_rst_o == 1'b0, "R3 cke and dll low", {cke_o, dll_rst_o}, 0);
    chk(freq_o == 4'h0, "R3 freq untouched", freq_o, 0);
    chk(done_o == 1'b1, "R3 done held", done_o, 1);
    backup_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_err++;
    $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    run_normal(4'h5, 1'b1, 2'b10, 3'b111);
    run_backup();
    run_normal(4'hA, 1'b0, 2'b01, 3'b010);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

endmodule